// File: doc/BRIEF.md
# Link-Partner Detection and Termination Sequencer

This block decides, for a repeater with two groups of two output lanes, which termination each lane presents and when the transmitters may drive. It watches an active-high power enable, an active-low detection reset and a detect enable per group. A qualified rising edge of the detection reset starts a single detection sequence for every enabled group. The sequence requests a slow common-mode ramp up and then a short ramp down, and it samples the comparator result of every lane while the ramp runs.

A group where at least one lane saw a receiver moves both of its lanes to 50 ohm receive and transmit termination and unsquelches them. A group where no lane saw one parks both lanes at high-Z receive termination, 1k transmit termination and a squelched transmitter with the common mode at the rail. A group whose detect enable is low skips detection and goes straight to 50 ohm. Per-lane sticky flags report the detection result. A per-group flag reports a detect enable that moved inside its required stable window around the start. All durations are given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `rxdet_term_ctrl`

## Requirements
- R1: While `pwr_en` is low, every lane shows `rx_term_on`=0, `tx_term_low`=0, `tx_squelch`=1 and `cm_mode`=0 (rail) in the same cycle. The sequencer and status are cleared at the next edge, and restoring power does not start a detection without a new qualified reset pulse.
- R2: While `det_rst_n` is low, every lane shows `rx_term_on`=0 and `tx_term_low`=0.
- R3: A rising edge of `det_rst_n` starts detection only if `det_rst_n` was sampled low on at least RST_MIN_NS worth of clock edges (10 edges at 50 MHz); a shorter pulse leaves the enabled groups at high-Z.
- R4: `cm_mode` per lane uses 2 bits at [2i+1:2i]: 0 rail, 1 ramp up, 2 ramp down, 3 active. After the edge that samples the `det_rst_n` rise, ramp up is shown from the second edge for RAMP_UP_NS worth of cycles, then ramp down for RAMP_DN_NS worth of cycles. During both ramps the lane shows high-Z, 1k and squelch.
- R5: `lane_sense` is sampled during both ramp phases. If any lane of a group (lanes 0-1 form group 0, lanes 2-3 form group 1) saw a 1, both lanes of that group end with 50 ohm on both sides, unsquelched, `cm_mode`=3.
- R6: If no lane of a group saw a receiver, both lanes end with high-Z, 1k, squelched and `cm_mode`=0.
- R7: With `grp_det_en` of a group low and `det_rst_n` high, both lanes of that group show 50 ohm, active, from the next edge, without any ramp and with `det_found` 0.
- R8: `det_found[i]` clears at the edge that samples `det_rst_n` low, takes lane i's detection result when the ramp down ends, and otherwise holds.
- R9: A group's `en_viol` bit sets if its detect enable is high at detection start but has been high for fewer than EN_SETUP_NS worth of cycles.
- R10: A group's `en_viol` bit sets if its detect enable falls within EN_HOLD_NS worth of cycles after detection start; `en_viol` clears at the edge that samples `det_rst_n` low.
- R11: Detection runs once per qualified pulse: after completion, `lane_sense` activity changes neither termination nor `det_found`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Chip power enable, low means full power-down |
| det_rst_n | input | 1 | Active-low detection reset; its rising edge starts detection |
| grp_det_en | input | NGRP | Detect enable per group |
| lane_sense | input | NLANE | Comparator result per lane, 1 = receiver seen |
| rx_term_on | output | NLANE | 1 = 50 ohm receive termination, 0 = high-Z |
| tx_term_low | output | NLANE | 1 = 50 ohm transmit termination, 0 = 1k |
| tx_squelch | output | NLANE | 1 = transmitter held quiet |
| cm_mode | output | 2*NLANE | Common-mode request per lane (R4 encoding) |
| det_found | output | NLANE | Sticky per-lane detection result |
| en_viol | output | NGRP | Detect-enable timing violation per group |

## Verification
A sequencer stuck in a ramp state or a miscounted ramp shows at `cm_mode` within one cycle of the expected phase boundary, so the bench samples both sides of each boundary. Wrong pooling appears as mismatched terminations within a group right at completion. A status register that fails to clear or hold is exposed by pulses that are deliberately too short and by comparator strobes sent after completion. A wrong enable-window counter shows on `en_viol` one edge after the start or after the offending change.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [2:0] {
        GS_HOLD    = 3'd0,
        GS_RAMP_UP = 3'd1,
        GS_RAMP_DN = 3'd2,
        GS_LINKED  = 3'd3,
        GS_NOLINK  = 3'd4
    } grp_state_e;

    typedef enum logic [1:0] {
        CM_RAIL   = 2'd0,
        CM_UP     = 2'd1,
        CM_DOWN   = 2'd2,
        CM_ACTIVE = 2'd3
    } cm_mode_e;

    typedef struct packed {
        logic     rx50;
        logic     tx50;
        logic     squelch;
        cm_mode_e cm;
    } lane_ctl_t;

    // Round a duration in ns up to whole cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_hz);
        longint prod;
        longint cyc;
        prod = longint'(ns) * longint'(clk_hz / 1000);
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

    function automatic lane_ctl_t lane_decode(input logic pwr_en,
                                              input logic det_rst_n,
                                              input grp_state_e st);
        lane_ctl_t c;
        c = '{rx50: 1'b0, tx50: 1'b0, squelch: 1'b1, cm: CM_RAIL};
        if (pwr_en && det_rst_n) begin
            unique case (st)
                GS_RAMP_UP: c.cm = CM_UP;
                GS_RAMP_DN: c.cm = CM_DOWN;
                GS_LINKED:  c = '{rx50: 1'b1, tx50: 1'b1, squelch: 1'b0, cm: CM_ACTIVE};
                default:    c.cm = CM_RAIL;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/rxdet_start_qual.sv
module rxdet_start_qual #(
    parameter int LOW_MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic det_rst_n,
    output logic start_o
);
    localparam int LW = $clog2(LOW_MIN_CYC + 1);
    localparam logic [LW-1:0] LOW_MIN = LW'(LOW_MIN_CYC);

    typedef struct packed {
        logic          prev;
        logic [LW-1:0] low_cnt;
        logic          start;
    } qual_t;

    qual_t q, d;

    always_comb begin
        d       = q;
        d.prev  = det_rst_n;
        d.start = pwr_en && det_rst_n && !q.prev && (q.low_cnt >= LOW_MIN);
        if (!pwr_en || det_rst_n) begin
            d.low_cnt = '0;
        end else if (q.low_cnt != LOW_MIN) begin
            d.low_cnt = q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{prev: 1'b1, low_cnt: '0, start: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start_o = q.start;
endmodule

// File: rtl/rxdet_group_seq.sv
module rxdet_group_seq
    import rxdet_pkg::*;
#(
    parameter int LPG     = 2,
    parameter int UP_CYC  = 40000,
    parameter int DN_CYC  = 75
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_en,
    input  logic           det_rst_n,
    input  logic           det_en,
    input  logic           start,
    input  logic [LPG-1:0] sense,
    output grp_state_e     state_o,
    output logic [LPG-1:0] found_o
);
    localparam int MAXC = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] UP_LOAD = CW'(UP_CYC - 1);
    localparam logic [CW-1:0] DN_LOAD = CW'(DN_CYC - 1);

    typedef struct packed {
        grp_state_e     st;
        logic [CW-1:0]  cnt;
        logic [LPG-1:0] hit;
        logic [LPG-1:0] found;
    } seq_t;

    seq_t q, d;
    logic [LPG-1:0] hit_nx;

    always_comb begin
        d      = q;
        hit_nx = q.hit | sense;
        if (!pwr_en || !det_rst_n) begin
            d.st    = GS_HOLD;
            d.cnt   = '0;
            d.hit   = '0;
            d.found = '0;
        end else begin
            unique case (q.st)
                GS_HOLD: begin
                    if (!det_en) begin
                        d.st = GS_LINKED;
                    end else if (start) begin
                        d.st  = GS_RAMP_UP;
                        d.cnt = UP_LOAD;
                        d.hit = '0;
                    end
                end
                GS_RAMP_UP: begin
                    d.hit = hit_nx;
                    if (q.cnt == '0) begin
                        d.st  = GS_RAMP_DN;
                        d.cnt = DN_LOAD;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                GS_RAMP_DN: begin
                    d.hit = hit_nx;
                    if (q.cnt == '0) begin
                        d.found = hit_nx;
                        d.st    = (|hit_nx) ? GS_LINKED : GS_NOLINK;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: GS_HOLD, cnt: '0, hit: '0, found: '0};
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;
    assign found_o = q.found;
endmodule

// File: rtl/rxdet_en_monitor.sv
module rxdet_en_monitor #(
    parameter int SETUP_CYC = 10,
    parameter int HOLD_CYC  = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic det_rst_n,
    input  logic det_en,
    input  logic start,
    output logic viol_o
);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [SW-1:0] SETUP_MIN = SW'(SETUP_CYC);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

    typedef struct packed {
        logic [SW-1:0] hi_cnt;
        logic [HW-1:0] win;
        logic          viol;
    } mon_t;

    mon_t q, d;

    always_comb begin
        d = q;
        if (!det_en) begin
            d.hi_cnt = '0;
        end else if (q.hi_cnt != SETUP_MIN) begin
            d.hi_cnt = q.hi_cnt + 1'b1;
        end

        if (!pwr_en) begin
            d = '0;
        end else if (!det_rst_n) begin
            d.win  = '0;
            d.viol = 1'b0;
        end else if (start && det_en) begin
            if (q.hi_cnt < SETUP_MIN) d.viol = 1'b1;
            d.win = HOLD_LOAD;
        end else if (q.win != '0) begin
            if (!det_en) begin
                d.viol = 1'b1;
                d.win  = '0;
            end else begin
                d.win = q.win - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign viol_o = q.viol;
endmodule

// File: rtl/rxdet_term_ctrl.sv
module rxdet_term_ctrl
    import rxdet_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int RST_MIN_NS  = 200,
    parameter int EN_SETUP_NS = 200,
    parameter int EN_HOLD_NS  = 2_000_000,
    parameter int RAMP_UP_NS  = 800_000,
    parameter int RAMP_DN_NS  = 1_500,
    parameter int NGRP        = 2,
    parameter int LPG         = 2,
    localparam int NLANE      = NGRP * LPG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_en,
    input  logic               det_rst_n,
    input  logic [NGRP-1:0]    grp_det_en,
    input  logic [NLANE-1:0]   lane_sense,
    output logic [NLANE-1:0]   rx_term_on,
    output logic [NLANE-1:0]   tx_term_low,
    output logic [NLANE-1:0]   tx_squelch,
    output logic [2*NLANE-1:0] cm_mode,
    output logic [NLANE-1:0]   det_found,
    output logic [NGRP-1:0]    en_viol
);
    localparam int RST_MIN_CYC  = ns_to_cyc(RST_MIN_NS, CLK_HZ);
    localparam int EN_SETUP_CYC = ns_to_cyc(EN_SETUP_NS, CLK_HZ);
    localparam int EN_HOLD_CYC  = ns_to_cyc(EN_HOLD_NS, CLK_HZ);
    localparam int RAMP_UP_CYC  = ns_to_cyc(RAMP_UP_NS, CLK_HZ);
    localparam int RAMP_DN_CYC  = ns_to_cyc(RAMP_DN_NS, CLK_HZ);

    logic       start;
    grp_state_e grp_state [NGRP];

    rxdet_start_qual #(
        .LOW_MIN_CYC(RST_MIN_CYC)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .det_rst_n (det_rst_n),
        .start_o   (start)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        rxdet_group_seq #(
            .LPG    (LPG),
            .UP_CYC (RAMP_UP_CYC),
            .DN_CYC (RAMP_DN_CYC)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwr_en    (pwr_en),
            .det_rst_n (det_rst_n),
            .det_en    (grp_det_en[g]),
            .start     (start),
            .sense     (lane_sense[g*LPG +: LPG]),
            .state_o   (grp_state[g]),
            .found_o   (det_found[g*LPG +: LPG])
        );

        rxdet_en_monitor #(
            .SETUP_CYC (EN_SETUP_CYC),
            .HOLD_CYC  (EN_HOLD_CYC)
        ) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwr_en    (pwr_en),
            .det_rst_n (det_rst_n),
            .det_en    (grp_det_en[g]),
            .start     (start),
            .viol_o    (en_viol[g])
        );

        for (genvar l = 0; l < LPG; l++) begin : g_lane
            lane_ctl_t ctl;
            assign ctl = lane_decode(pwr_en, det_rst_n, grp_state[g]);
            assign rx_term_on[g*LPG + l]        = ctl.rx50;
            assign tx_term_low[g*LPG + l]       = ctl.tx50;
            assign tx_squelch[g*LPG + l]        = ctl.squelch;
            assign cm_mode[2*(g*LPG + l) +: 2]  = ctl.cm;
        end
    end
endmodule

// File: rtl/rxdet_term_ctrl_chk.sv
module rxdet_term_ctrl_chk #(
    parameter int NGRP  = 2,
    parameter int LPG   = 2,
    parameter int NLANE = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_en,
    input logic               det_rst_n,
    input logic [NLANE-1:0]   rx_term_on,
    input logic [NLANE-1:0]   tx_term_low,
    input logic [NLANE-1:0]   tx_squelch,
    input logic [2*NLANE-1:0] cm_mode,
    input logic [NLANE-1:0]   det_found,
    input logic [NGRP-1:0]    en_viol
);
    logic [NLANE-1:0] lane_dn;
    for (genvar i = 0; i < NLANE; i++) begin : g_dn
        assign lane_dn[i] = (cm_mode[2*i +: 2] == 2'd2);
    end

    a_r1_pd_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (rx_term_on == '0 && tx_term_low == '0 && cm_mode == '0 && tx_squelch == '1));

    a_r2_rst_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !det_rst_n |-> (rx_term_on == '0 && tx_term_low == '0));

    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !det_rst_n |=> (det_found == '0));

    a_r8_status_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && det_rst_n && $past(pwr_en) && $past(det_rst_n) && det_found != $past(det_found))
        |-> $past(|lane_dn));

    a_r10_viol_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !det_rst_n |=> (en_viol == '0));

    for (genvar g = 0; g < NGRP; g++) begin : g_pair
        for (genvar l = 1; l < LPG; l++) begin : g_l
            a_r5_pooled: assert property (@(posedge clk) disable iff (!rst_n)
                (rx_term_on[g*LPG + l] == rx_term_on[g*LPG] &&
                 tx_term_low[g*LPG + l] == tx_term_low[g*LPG]));
        end
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_ramp
        a_r4_ramp_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (cm_mode[2*i +: 2] == 2'd1 || cm_mode[2*i +: 2] == 2'd2)
            |-> (!rx_term_on[i] && !tx_term_low[i] && tx_squelch[i]));
    end
endmodule

bind rxdet_term_ctrl rxdet_term_ctrl_chk #(
    .NGRP  (NGRP),
    .LPG   (LPG),
    .NLANE (NLANE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_en      (pwr_en),
    .det_rst_n   (det_rst_n),
    .rx_term_on  (rx_term_on),
    .tx_term_low (tx_term_low),
    .tx_squelch  (tx_squelch),
    .cm_mode     (cm_mode),
    .det_found   (det_found),
    .en_viol     (en_viol)
);

// File: tb/rxdet_term_ctrl_tb.sv
module rxdet_term_ctrl_tb;
    localparam int UP = 100;
    localparam int DN = 10;

    logic       clk = 1'b0;
    logic       rst_n, pwr_en, det_rst_n;
    logic [1:0] grp_det_en;
    logic [3:0] lane_sense;
    logic [3:0] rx_term_on, tx_term_low, tx_squelch, det_found;
    logic [7:0] cm_mode;
    logic [1:0] en_viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rxdet_term_ctrl #(
        .CLK_HZ     (50_000_000),
        .RAMP_UP_NS (2000),
        .RAMP_DN_NS (200),
        .EN_HOLD_NS (4000)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .det_rst_n(det_rst_n),
        .grp_det_en(grp_det_en), .lane_sense(lane_sense),
        .rx_term_on(rx_term_on), .tx_term_low(tx_term_low), .tx_squelch(tx_squelch),
        .cm_mode(cm_mode), .det_found(det_found), .en_viol(en_viol)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_all(input string req, input logic [3:0] rx, input logic [3:0] tx,
                           input logic [3:0] sq, input logic [7:0] cm);
        chk(req, "rx_term_on", 32'(rx_term_on), 32'(rx));
        chk(req, "tx_term_low", 32'(tx_term_low), 32'(tx));
        chk(req, "tx_squelch", 32'(tx_squelch), 32'(sq));
        chk(req, "cm_mode", 32'(cm_mode), 32'(cm));
    endtask

    // Release det_rst_n, strobe mask mid ramp-up, check phase edges (R4),
    // return after the final state is visible.
    task automatic detect_seq(input logic [3:0] mask, input logic [7:0] cm_up,
                              input logic [7:0] cm_dn);
        det_rst_n = 1'b1;
        wait_n(2);
        chk("R4", "ramp up start", 32'(cm_mode), 32'(cm_up));
        wait_n(48);
        lane_sense = mask;
        wait_n(1);
        lane_sense = '0;
        wait_n(UP - 50);
        chk("R4", "ramp up last", 32'(cm_mode), 32'(cm_up));
        wait_n(1);
        chk("R4", "ramp down first", 32'(cm_mode), 32'(cm_dn));
        wait_n(DN - 1);
        chk("R4", "ramp down last", 32'(cm_mode), 32'(cm_dn));
        wait_n(1);
    endtask

    task automatic t_reset();
        chk_all("R2", 4'b0000, 4'b0000, 4'b1111, 8'h00);
        chk("R8", "det_found reset", 32'(det_found), 32'h0);
        chk("R10", "en_viol reset", 32'(en_viol), 32'h0);
    endtask

    task automatic t_detect_a();
        detect_seq(4'b0010, 8'b0101_0101, 8'b1010_1010);
        chk_all("R5 R6", 4'b0011, 4'b0011, 4'b1100, 8'b0000_1111);
        chk("R8", "det_found lane1", 32'(det_found), 32'h2);
        chk("R9", "no setup violation", 32'(en_viol), 32'h0);
    endtask

    task automatic t_once();
        lane_sense = 4'b1101;
        wait_n(2);
        lane_sense = '0;
        wait_n(2);
        chk("R11", "rx after late sense", 32'(rx_term_on), 32'h3);
        chk("R11", "det_found after late sense", 32'(det_found), 32'h2);
    endtask

    task automatic t_short();
        det_rst_n = 1'b0;
        wait_n(1);
        chk("R8", "det_found cleared", 32'(det_found), 32'h0);
        chk("R2", "rx during reset", 32'(rx_term_on), 32'h0);
        wait_n(8);
        det_rst_n = 1'b1;
        wait_n(UP + DN + 5);
        chk_all("R3", 4'b0000, 4'b0000, 4'b1111, 8'h00);
    endtask

    task automatic t_detect_b();
        det_rst_n = 1'b0;
        wait_n(10);
        detect_seq(4'b1100, 8'b0101_0101, 8'b1010_1010);
        chk_all("R5 R6", 4'b1100, 4'b1100, 4'b0011, 8'b1111_0000);
        chk("R8", "det_found group1", 32'(det_found), 32'hC);
        chk("R3", "min pulse viol", 32'(en_viol), 32'h0);
    endtask

    task automatic t_power();
        pwr_en = 1'b0;
        #1;
        chk_all("R1", 4'b0000, 4'b0000, 4'b1111, 8'h00);
        wait_n(2);
        chk("R1", "det_found in power-down", 32'(det_found), 32'h0);
        pwr_en = 1'b1;
        wait_n(3);
        chk_all("R1", 4'b0000, 4'b0000, 4'b1111, 8'h00);
    endtask

    task automatic t_bypass();
        det_rst_n  = 1'b0;
        grp_det_en = 2'b01;
        wait_n(12);
        detect_seq(4'b0000, 8'b1111_0101, 8'b1111_1010);
        chk_all("R7 R6", 4'b1100, 4'b1100, 4'b0011, 8'b1111_0000);
        chk("R7", "det_found bypass", 32'(det_found), 32'h0);
        chk("R7", "en_viol bypass", 32'(en_viol), 32'h0);
    endtask

    task automatic t_setup_viol();
        det_rst_n  = 1'b0;
        grp_det_en = 2'b00;
        wait_n(20);
        grp_det_en = 2'b11;
        wait_n(3);
        det_rst_n = 1'b1;
        wait_n(3);
        chk("R9", "setup violation", 32'(en_viol), 32'h3);
        wait_n(UP + DN + 5);
    endtask

    task automatic t_hold_viol();
        det_rst_n = 1'b0;
        wait_n(15);
        chk("R10", "viol cleared by reset", 32'(en_viol), 32'h0);
        det_rst_n = 1'b1;
        wait_n(20);
        chk("R10", "no violation yet", 32'(en_viol), 32'h0);
        grp_det_en = 2'b10;
        wait_n(2);
        chk("R10", "hold violation group0", 32'(en_viol), 32'h1);
        det_rst_n = 1'b0;
        wait_n(2);
        chk("R10", "viol cleared", 32'(en_viol), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; pwr_en = 1'b1; det_rst_n = 1'b0;
        grp_det_en = 2'b11; lane_sense = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(15);
        t_reset();
        t_detect_a();
        t_once();
        t_short();
        t_detect_b();
        t_power();
        t_bypass();
        t_setup_viol();
        t_hold_viol();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule